// File: doc/BRIEF.md
# Error Collector and Reset Requester

This block gathers error reports from a set of on-chip sources and turns them into one reset-request line for external safety logic. Every report carries a class flag (correctable or uncorrectable) and a syndrome word. Uncorrectable reports escalate on the next clock edge. Correctable reports are counted per source, and they escalate only when that source's count reaches a configured threshold. The first syndrome seen by each source is held until software reads it.

Watchdog expiry lines feed the same request. Each per-core watchdog has its own mask bit. The secure-world watchdog can be masked only while the debug-mode input is high. Software can also force a request by writing the reset-control register.

Every escalation sets a sticky status bit, and the request output is the OR of all the status bits. A read of the status register clears the status bits. The register bus uses single-cycle strobes with combinational read data, and a read has its side effect at the clock edge that ends it.

Top module: `err_collector`

## Requirements
- R1: After reset, reset_req_o is 0, the status, mask and counter registers read 0, and every syndrome slot reads 0.
- R2: An uncorrectable report on source i (err_vld_i[i]=1 and err_fatal_i[i]=1) sets status bit i at the next clock edge, and reset_req_o goes high at that edge. Such a report does not change the source's correctable counter.
- R3: A correctable report on source i (err_vld_i[i]=1 and err_fatal_i[i]=0) adds one to the counter of source i, which reads at address CNT_BASE+i (CNT_BASE=SYN_BASE+N_SRC). Status bit i is set only by the report that brings the count to CE_THRESH. Reports below the threshold and reports after it raise no request.
- R4: Each counter stops at 2^CNT_W-1. A write of any value to the counter's address clears it, and threshold counting then starts again from zero.
- R5: Status bits at address 0 are sticky. A read of address 0 returns their value and clears them at the edge that ends the read, but a bit set in that same cycle stays set. reset_req_o is 1 while any status bit is 1.
- R6: The syndrome slot of source i, at address SYN_BASE+i (SYN_BASE=4), reads valid at bit DATA_W-1, the class at bit DATA_W-2 (1 = uncorrectable) and the syndrome in bits SYN_W-1:0. A slot captures a report only while it is empty. A read empties it. Sources that report in the same cycle each capture their own data.
- R7: Expiry of core watchdog j sets status bit N_SRC+j unless bit j of the core mask register (address 1) is 1.
- R8: Expiry of the secure watchdog sets status bit N_SRC+N_CORE, except while debug_mode_i is 1 and bit 0 of the secure mask register (address 2) is 1.
- R9: A write to the reset-control address 3 with bit 0 = 1 sets status bit N_SRC+N_CORE+1. A write with bit 0 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_vld_i | input | N_SRC | Per-source error report strobe |
| err_fatal_i | input | N_SRC | Per-source class: 1 = uncorrectable |
| err_syn_i | input | N_SRC*SYN_W | Per-source syndrome, source i in slice i |
| core_wdog_i | input | N_CORE | Per-core watchdog expiry |
| sec_wdog_i | input | 1 | Secure-world watchdog expiry |
| debug_mode_i | input | 1 | Device is in debug mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| reset_req_o | output | 1 | Reset request to external safety logic |

## Verification
The bench builds the block with N_SRC=4, N_CORE=2, SYN_W=16, CNT_W=3 and CE_THRESH=3. With a three-bit counter, saturation at 7 is reached in a handful of reports, so the bench checks both the single escalation at the threshold and the stop at the maximum. Two cores are enough to show one masked expiry and one unmasked expiry side by side. With four sources, the bench can send an uncorrectable report and a correctable report in the same cycle, and it can collide a status read with a new report in the same cycle.

// File: rtl/err_pkg.sv
package err_pkg;
  localparam int ADDR_STATUS = 0;
  localparam int ADDR_CMASK  = 1;
  localparam int ADDR_SMASK  = 2;
  localparam int ADDR_RSTCTL = 3;
  localparam int SYN_BASE    = 4;
endpackage

// File: rtl/err_ce_counter.sv
module err_ce_counter #(
  parameter int CNT_W  = 8,
  parameter int THRESH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   THR     = (CNT_W+1)'(THRESH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clr_i)                       cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
  end

  // escalate only on the report that crosses the threshold
  assign hit_o = inc_i && !clr_i && (cnt_q != CNT_MAX) && (({1'b0, cnt_q} + 1'b1) == THR);
  assign cnt_o = cnt_q;

  assert_cnt_sat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
  assert_cnt_clr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/err_syn_slot.sv
module err_syn_slot #(
  parameter int SYN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             fatal_i,
  input  logic [SYN_W-1:0] syn_i,
  input  logic             rd_i,
  output logic             vld_o,
  output logic             fatal_o,
  output logic [SYN_W-1:0] syn_o
);
  logic             vld_q, fatal_q;
  logic [SYN_W-1:0] syn_q;
  logic             free;

  // a slot read in this cycle may take the new report
  assign free = !vld_q || rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q   <= 1'b0;
      fatal_q <= 1'b0;
      syn_q   <= '0;
    end else if (free) begin
      vld_q <= cap_i;
      if (cap_i) begin
        fatal_q <= fatal_i;
        syn_q   <= syn_i;
      end else begin
        fatal_q <= 1'b0;
        syn_q   <= '0;
      end
    end
  end

  assign vld_o   = vld_q;
  assign fatal_o = fatal_q;
  assign syn_o   = syn_q;

  assert_syn_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_q && !rd_i) |=> (vld_q && $stable(syn_q) && $stable(fatal_q)));
endmodule

// File: rtl/err_wdog_gate.sv
module err_wdog_gate #(
  parameter int N_CORE = 4
) (
  input  logic [N_CORE-1:0] core_wdog_i,
  input  logic [N_CORE-1:0] core_mask_i,
  input  logic              sec_wdog_i,
  input  logic              sec_mask_i,
  input  logic              debug_mode_i,
  output logic [N_CORE-1:0] core_req_o,
  output logic              sec_req_o
);
  assign core_req_o = core_wdog_i & ~core_mask_i;
  // the secure mask only counts in debug mode
  assign sec_req_o  = sec_wdog_i & ~(sec_mask_i & debug_mode_i);
endmodule

// File: rtl/err_collector.sv
module err_collector
  import err_pkg::*;
#(
  parameter int N_SRC     = 4,
  parameter int N_CORE    = 4,
  parameter int SYN_W     = 16,
  parameter int CNT_W     = 8,
  parameter int CE_THRESH = 16,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        err_vld_i,
  input  logic [N_SRC-1:0]        err_fatal_i,
  input  logic [N_SRC*SYN_W-1:0]  err_syn_i,
  input  logic [N_CORE-1:0]       core_wdog_i,
  input  logic                    sec_wdog_i,
  input  logic                    debug_mode_i,
  input  logic                    reg_we_i,
  input  logic                    reg_re_i,
  input  logic [ADDR_W-1:0]       reg_addr_i,
  input  logic [DATA_W-1:0]       reg_wdata_i,
  output logic [DATA_W-1:0]       reg_rdata_o,
  output logic                    reset_req_o
);
  localparam int CNT_BASE = SYN_BASE + N_SRC;
  localparam int ST_W     = N_SRC + N_CORE + 2;
  localparam int SEC_BIT  = N_SRC + N_CORE;
  localparam int SW_BIT   = N_SRC + N_CORE + 1;

  logic [ST_W-1:0]             status_q, st_set;
  logic [N_CORE-1:0]           core_mask_q, core_req;
  logic                        sec_mask_q, sec_req;
  logic [N_SRC-1:0]            src_set, syn_vld, syn_fat;
  logic [N_SRC-1:0][SYN_W-1:0] syn_dat;
  logic [N_SRC-1:0][CNT_W-1:0] cnt;
  logic                        rd_status, sw_req;

  assign rd_status = reg_re_i && reg_addr_i == ADDR_W'(ADDR_STATUS);
  assign sw_req    = reg_we_i && reg_addr_i == ADDR_W'(ADDR_RSTCTL) && reg_wdata_i[0];

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic ce_hit;
    err_ce_counter #(.CNT_W(CNT_W), .THRESH(CE_THRESH)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (err_vld_i[i] && !err_fatal_i[i]),
      .clr_i (reg_we_i && reg_addr_i == ADDR_W'(CNT_BASE + i)),
      .cnt_o (cnt[i]),
      .hit_o (ce_hit)
    );
    err_syn_slot #(.SYN_W(SYN_W)) u_syn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cap_i  (err_vld_i[i]),
      .fatal_i(err_fatal_i[i]),
      .syn_i  (err_syn_i[i*SYN_W +: SYN_W]),
      .rd_i   (reg_re_i && reg_addr_i == ADDR_W'(SYN_BASE + i)),
      .vld_o  (syn_vld[i]),
      .fatal_o(syn_fat[i]),
      .syn_o  (syn_dat[i])
    );
    assign src_set[i] = (err_vld_i[i] && err_fatal_i[i]) || ce_hit;
  end

  err_wdog_gate #(.N_CORE(N_CORE)) u_wdog (
    .core_wdog_i (core_wdog_i),
    .core_mask_i (core_mask_q),
    .sec_wdog_i  (sec_wdog_i),
    .sec_mask_i  (sec_mask_q),
    .debug_mode_i(debug_mode_i),
    .core_req_o  (core_req),
    .sec_req_o   (sec_req)
  );

  assign st_set = {sw_req, sec_req, core_req, src_set};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q    <= '0;
      core_mask_q <= '0;
      sec_mask_q  <= 1'b0;
    end else begin
      // new sets win over the read-clear
      status_q <= (rd_status ? '0 : status_q) | st_set;
      if (reg_we_i && reg_addr_i == ADDR_W'(ADDR_CMASK)) core_mask_q <= reg_wdata_i[N_CORE-1:0];
      if (reg_we_i && reg_addr_i == ADDR_W'(ADDR_SMASK)) sec_mask_q  <= reg_wdata_i[0];
    end
  end

  assign reset_req_o = |status_q;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_W'(ADDR_STATUS)) reg_rdata_o[ST_W-1:0]   = status_q;
    if (reg_addr_i == ADDR_W'(ADDR_CMASK))  reg_rdata_o[N_CORE-1:0] = core_mask_q;
    if (reg_addr_i == ADDR_W'(ADDR_SMASK))  reg_rdata_o[0]          = sec_mask_q;
    for (int i = 0; i < N_SRC; i++) begin
      if (reg_addr_i == ADDR_W'(SYN_BASE + i)) begin
        reg_rdata_o[DATA_W-1]  = syn_vld[i];
        reg_rdata_o[DATA_W-2]  = syn_fat[i];
        reg_rdata_o[SYN_W-1:0] = syn_dat[i];
      end
      if (reg_addr_i == ADDR_W'(CNT_BASE + i)) reg_rdata_o[CNT_W-1:0] = cnt[i];
    end
  end

  assert_fatal_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(err_vld_i & err_fatal_i)) |=> reset_req_o);
  assert_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reset_req_o && !rd_status) |=> reset_req_o);
  assert_core_wdog_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(core_wdog_i & ~core_mask_q)) |=> reset_req_o);
  assert_sec_wdog_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_wdog_i && !debug_mode_i) |=> reset_req_o);
  assert_sw_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_W'(ADDR_RSTCTL) && reg_wdata_i[0]) |=> reset_req_o);
endmodule

// File: tb/err_collector_test.sv
`timescale 1ns/1ps
module err_collector_test;
  localparam int N_SRC = 4, N_CORE = 2, SYN_W = 16, CNT_W = 3, THR = 3;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic [N_SRC-1:0]  err_vld_i = '0, err_fatal_i = '0;
  logic [N_SRC*SYN_W-1:0] err_syn_i = '0;
  logic [N_CORE-1:0] core_wdog_i = '0;
  logic              sec_wdog_i = 1'b0, debug_mode_i = 1'b0;
  logic              reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [3:0]        reg_addr_i = '0;
  logic [31:0]       reg_wdata_i = '0, reg_rdata_o;
  logic              reset_req_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  err_collector #(.N_SRC(N_SRC), .N_CORE(N_CORE), .SYN_W(SYN_W), .CNT_W(CNT_W),
                  .CE_THRESH(THR), .ADDR_W(4), .DATA_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .err_vld_i(err_vld_i), .err_fatal_i(err_fatal_i),
    .err_syn_i(err_syn_i), .core_wdog_i(core_wdog_i), .sec_wdog_i(sec_wdog_i),
    .debug_mode_i(debug_mode_i), .reg_we_i(reg_we_i), .reg_re_i(reg_re_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .reset_req_o(reset_req_o));

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (rst_ni && reg_re_i) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: got %h expected none", reg_rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (reg_rdata_o !== e) begin
          n_bad++;
          $display("FAIL %s: read addr %0d got %h expected %h", t, reg_addr_i, reg_rdata_o, e);
        end
      end
    end
  end

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1; reg_re_i = 1'b1; reg_addr_i = a;
    @(posedge clk); #1; reg_re_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1; reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk); #1; reg_we_i = 1'b0;
  endtask

  task automatic evt(input logic [3:0] v, input logic [3:0] f, input logic [63:0] s);
    @(posedge clk); #1; err_vld_i = v; err_fatal_i = f; err_syn_i = s;
    @(posedge clk); #1; err_vld_i = '0; err_fatal_i = '0; err_syn_i = '0;
  endtask

  task automatic ce0(input logic [15:0] s);
    evt(4'b0001, 4'b0000, {48'h0, s});
  endtask

  task automatic wdog(input logic [1:0] c, input logic s);
    @(posedge clk); #1; core_wdog_i = c; sec_wdog_i = s;
    @(posedge clk); #1; core_wdog_i = '0; sec_wdog_i = 1'b0;
  endtask

  task automatic chk_req(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (reset_req_o !== e) begin
      n_bad++;
      $display("FAIL %s: reset_req_o got %b expected %b", t, reset_req_o, e);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    // R1 reset state
    chk_req(1'b0, "R1 req after reset");
    rd(0, 32'h0, "R1 status");
    rd(4, 32'h0, "R1 syndrome slot");
    rd(8, 32'h0, "R1 counter");
    rd(1, 32'h0, "R1 core mask");

    // R3 below threshold, R6 first syndrome kept
    ce0(16'h1111);
    ce0(16'h2222);
    chk_req(1'b0, "R3 below threshold");
    rd(8, 32'd2, "R3 count two");
    rd(4, 32'h8000_1111, "R6 first syndrome kept");
    rd(4, 32'h0, "R6 read empties slot");
    // R3 threshold crossing
    ce0(16'h3333);
    chk_req(1'b1, "R3 threshold reached");
    rd(8, 32'd3, "R3 count three");
    rd(4, 32'h8000_3333, "R6 capture after empty");
    rd(0, 32'h1, "R5 status bit0");
    chk_req(1'b0, "R5 cleared by read");

    // R4 saturation, no re-escalation
    for (int k = 0; k < 5; k++) ce0(16'h4444);
    rd(8, 32'd7, "R4 saturated count");
    chk_req(1'b0, "R3 no escalation past threshold");
    wr(8, 32'h0);
    rd(8, 32'd0, "R4 clear counter");
    ce0(16'h5555);
    ce0(16'h5555);
    chk_req(1'b0, "R4 restart below threshold");
    ce0(16'h5555);
    chk_req(1'b1, "R4 restart reaches threshold");
    rd(0, 32'h1, "R4 status after restart");
    rd(4, 32'h8000_4444, "R6 slot holds first of burst");

    // R2 fatal plus concurrent correctable on another source
    evt(4'b0110, 4'b0010, {16'h0, 16'h0042, 16'hBEEF, 16'h0});
    chk_req(1'b1, "R2 fatal immediate");
    rd(5, 32'hC000_BEEF, "R6 fatal syndrome src1");
    rd(6, 32'h8000_0042, "R6 concurrent syndrome src2");
    rd(10, 32'd1, "R3 src2 counted");
    rd(9, 32'd0, "R2 fatal not counted");
    repeat (5) @(posedge clk);
    chk_req(1'b1, "R5 sticky while unread");
    // R5 read-clear collides with a new fatal on src3
    exp_q.push_back(32'h2); tag_q.push_back("R5 read during new set");
    @(posedge clk); #1;
    reg_re_i = 1'b1; reg_addr_i = 4'd0;
    err_vld_i = 4'b1000; err_fatal_i = 4'b1000; err_syn_i = {16'h0ABC, 48'h0};
    @(posedge clk); #1;
    reg_re_i = 1'b0; err_vld_i = '0; err_fatal_i = '0; err_syn_i = '0;
    chk_req(1'b1, "R5 set wins over clear");
    rd(0, 32'h8, "R5 src3 bit kept");
    chk_req(1'b0, "R5 all clear");

    // R7 core watchdog masking
    wr(1, 32'h1);
    rd(1, 32'h1, "R7 mask readback");
    wdog(2'b01, 1'b0);
    chk_req(1'b0, "R7 masked core ignored");
    rd(0, 32'h0, "R7 masked core no status");
    wdog(2'b10, 1'b0);
    chk_req(1'b1, "R7 unmasked core");
    rd(0, 32'h20, "R7 core1 status bit");

    // R8 secure watchdog
    wr(2, 32'h1);
    debug_mode_i = 1'b0;
    wdog(2'b00, 1'b1);
    chk_req(1'b1, "R8 mask ignored outside debug");
    rd(0, 32'h40, "R8 secure status bit");
    debug_mode_i = 1'b1;
    wdog(2'b00, 1'b1);
    chk_req(1'b0, "R8 masked in debug");
    rd(0, 32'h0, "R8 masked no status");
    wr(2, 32'h0);
    wdog(2'b00, 1'b1);
    chk_req(1'b1, "R8 unmasked in debug");
    rd(0, 32'h40, "R8 status debug unmasked");
    debug_mode_i = 1'b0;

    // R9 software request
    wr(3, 32'h0);
    chk_req(1'b0, "R9 bit0 clear no effect");
    wr(3, 32'h1);
    chk_req(1'b1, "R9 software request");
    rd(0, 32'h80, "R9 status bit");
    chk_req(1'b0, "R9 cleared");

    repeat (2) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule